// File: doc/BRIEF.md
# Fixed-Step Pixel Output Sequencer

This block paces pixel output for a video capture path that runs from a fast local clock while the pixel data belongs to a slower host CPU clock. Every host CPU cycle carries a group of eight pixels. The block spaces them by a whole number of fast-clock ticks, because the fast clock cannot divide the CPU period exactly. It then restarts the group at every rising CPU clock edge, so the rounding error of the group is absorbed by the eighth pixel, which stretches or shrinks as needed. The first seven pixels always keep the programmed width.

The CPU clock arrives unsynchronised. It passes through a two-stage synchroniser and a rising-edge detector before it starts a group. Two tick counts are supplied, one for each video standard, and a mode input picks one of them. The selected count is captured when a group starts and holds for the whole group. Downstream logic uses the one-cycle strobe and the 3-bit index to place each pixel.

Top module: `pxs_seq_top`

## Requirements
- R1: While reset is asserted and after it is released, until the first CPU rising edge is seen, `pix_valid` is 0 and `pix_idx` is 0.
- R2: If the first fast-clock edge to sample `cpu_clk_in` high after it was low is edge k, the pixel-0 strobe is asserted after edge k+2. A falling CPU edge produces no strobe.
- R3: Each CPU rising edge starts a new group: `pix_valid` is high for one cycle with `pix_idx` = 0.
- R4: Within a group, each further strobe comes exactly S fast-clock cycles after the previous one, and `pix_idx` goes up by one. S is `step_ntsc` when `mode_ntsc` = 1 and `step_pal` when `mode_ntsc` = 0, as sampled at the group start.
- R5: A group issues at most eight strobes (index 0 to 7). After index 7 no strobe occurs until the next CPU rising edge, so the eighth pixel lasts as long as the remaining time of the CPU period.
- R6: If a CPU rising edge's pixel-0 slot falls on or before the slot of a pixel not yet issued, that pixel is dropped and the group restarts at index 0. With period P and step S, only pixels j with j*S < P are issued.
- R7: A selected step value of 0 acts as a step of 1.
- R8: Changes to `mode_ntsc`, `step_pal` or `step_ntsc` after a group has started do not change that group's spacing. They apply from the next group.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast sampling clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpu_clk_in | input | 1 | Host CPU clock, asynchronous to clk |
| mode_ntsc | input | 1 | 1 selects the NTSC step count, 0 selects the PAL step count |
| step_pal | input | 8 | Pixel spacing in clk ticks for PAL mode |
| step_ntsc | input | 8 | Pixel spacing in clk ticks for NTSC mode |
| pix_valid | output | 1 | One-cycle strobe, one per pixel |
| pix_idx | output | 3 | Index of the pixel within the current group |

## Verification
A wrong tick counter or step latch shows at the next strobe of the group as a strobe at the wrong cycle, so it is visible within one step interval. A wrong index register or group terminator shows as a wrong `pix_idx`, a ninth strobe, or a missing restart at the following CPU edge, so it is visible within one CPU period. A synchroniser of the wrong depth moves every pixel-0 strobe by whole cycles, and the scoreboard sees this at the first group. Each strobe is compared against a cycle-exact expected time and index, and any strobe with no expected item is flagged.

// File: rtl/pxs_pkg.sv
package pxs_pkg;
  localparam int PXS_STEP_W = 8;
  typedef logic [PXS_STEP_W-1:0] step_t;

  // A zero step would stall the counter; treat it as one tick.
  function automatic step_t eff_step(input step_t raw);
    return (raw == '0) ? step_t'(1) : raw;
  endfunction

  function automatic step_t pick_step(input logic ntsc, input step_t s_pal,
                                      input step_t s_ntsc);
    return eff_step(ntsc ? s_ntsc : s_pal);
  endfunction
endpackage

// File: rtl/pxs_cpu_sync.sv
module pxs_cpu_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic rise_o
);
  logic [STAGES-1:0] chain_q;
  logic              hist_q;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[0] <= 1'b0;
          else        chain_q[0] <= async_in;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[g] <= 1'b0;
          else        chain_q[g] <= chain_q[g-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hist_q <= 1'b0;
    else        hist_q <= chain_q[STAGES-1];
  end

  assign rise_o = chain_q[STAGES-1] & ~hist_q;
endmodule

// File: rtl/pxs_step_sel.sv
module pxs_step_sel
  import pxs_pkg::*;
(
  input  logic  mode_ntsc,
  input  step_t step_pal,
  input  step_t step_ntsc,
  output step_t step_o
);
  always_comb step_o = pick_step(mode_ntsc, step_pal, step_ntsc);
endmodule

// File: rtl/pxs_pixel_timer.sv
module pxs_pixel_timer
  import pxs_pkg::*;
#(
  parameter int GROUP_PIXELS = 8,
  parameter int IDX_W = $clog2(GROUP_PIXELS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  step_t            step_i,
  output logic             valid_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             fire_o
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(GROUP_PIXELS - 1);

  step_t            step_q;
  step_t            tick_q;
  logic [IDX_W-1:0] idx_q;
  logic             active_q;
  logic             valid_q;

  // Interval boundary reached while the group still has pixels to issue.
  assign fire_o = active_q && (tick_q == step_q - step_t'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step_q   <= step_t'(1);
      tick_q   <= '0;
      idx_q    <= '0;
      active_q <= 1'b0;
      valid_q  <= 1'b0;
    end else if (start_i) begin
      step_q   <= step_i;
      tick_q   <= '0;
      idx_q    <= '0;
      active_q <= 1'b1;
      valid_q  <= 1'b1;
    end else if (fire_o) begin
      tick_q   <= '0;
      idx_q    <= idx_q + 1'b1;
      active_q <= (idx_q + 1'b1) != LAST_IDX;
      valid_q  <= 1'b1;
    end else begin
      if (active_q) tick_q <= tick_q + step_t'(1);
      valid_q <= 1'b0;
    end
  end

  assign valid_o = valid_q;
  assign idx_o   = idx_q;
endmodule

// File: rtl/pxs_seq_top.sv
module pxs_seq_top
  import pxs_pkg::*;
#(
  parameter int GROUP_PIXELS = 8,
  parameter int SYNC_STAGES  = 2,
  localparam int IDX_W = $clog2(GROUP_PIXELS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cpu_clk_in,
  input  logic             mode_ntsc,
  input  logic [7:0]       step_pal,
  input  logic [7:0]       step_ntsc,
  output logic             pix_valid,
  output logic [IDX_W-1:0] pix_idx
);
  // Named internal events, visible to the bound checker.
  logic  grp_start;
  logic  pix_fire;
  step_t sel_step;

  pxs_cpu_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_in(cpu_clk_in),
    .rise_o  (grp_start)
  );

  pxs_step_sel sel_i (
    .mode_ntsc(mode_ntsc),
    .step_pal (step_t'(step_pal)),
    .step_ntsc(step_t'(step_ntsc)),
    .step_o   (sel_step)
  );

  pxs_pixel_timer #(.GROUP_PIXELS(GROUP_PIXELS), .IDX_W(IDX_W)) tmr_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .start_i(grp_start),
    .step_i (sel_step),
    .valid_o(pix_valid),
    .idx_o  (pix_idx),
    .fire_o (pix_fire)
  );
endmodule

// File: rtl/pxs_seq_chk.sv
module pxs_seq_chk #(
  parameter int GROUP_PIXELS = 8,
  parameter int IDX_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cpu_clk_in,
  input logic             mode_ntsc,
  input logic [7:0]       step_pal,
  input logic [7:0]       step_ntsc,
  input logic             pix_valid,
  input logic [IDX_W-1:0] pix_idx,
  input logic             grp_start,
  input logic             pix_fire
);
  logic [2:0]       since_rst;
  logic [8:0]       gap;
  logic [7:0]       grp_step;
  logic [IDX_W:0]   seen;
  logic [IDX_W-1:0] last_idx;
  logic [7:0]       raw_step;

  assign raw_step = mode_ntsc ? step_ntsc : step_pal;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      since_rst <= '0;
      gap       <= '0;
      grp_step  <= 8'd1;
      seen      <= '0;
      last_idx  <= '0;
    end else begin
      if (since_rst != 3'd7) since_rst <= since_rst + 3'd1;
      if (pix_valid)           gap <= 9'd1;
      else if (gap != 9'h1ff)  gap <= gap + 9'd1;
      if (grp_start) grp_step <= (raw_step == 8'd0) ? 8'd1 : raw_step;
      if (pix_valid) begin
        seen     <= (pix_idx == '0) ? (IDX_W+1)'(1) : seen + 1'b1;
        last_idx <= pix_idx;
      end
    end
  end

  AST_START_IDX0: assert property (@(posedge clk) disable iff (!rst_n)
    grp_start |=> (pix_valid && pix_idx == '0)); // R3

  AST_IDX0_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid && pix_idx == '0) |-> $past(grp_start)); // R6

  AST_SYNC_LAT: assert property (@(posedge clk) disable iff (!rst_n)
    (grp_start && since_rst >= 3'd3) |-> ($past(cpu_clk_in, 2) && !$past(cpu_clk_in, 3))); // R2

  AST_IDX_SEQ: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid && pix_idx != '0) |-> (pix_idx == last_idx + 1'b1)); // R4

  AST_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid && pix_idx != '0) |-> (gap == {1'b0, grp_step})); // R8

  AST_MAX_GROUP: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid && pix_idx != '0) |-> (seen < (IDX_W+1)'(GROUP_PIXELS))); // R5

  AST_FIRE_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_fire && !grp_start) |=> (pix_valid && pix_idx != '0)); // R4
endmodule

bind pxs_seq_top pxs_seq_chk #(.GROUP_PIXELS(GROUP_PIXELS), .IDX_W(IDX_W)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .cpu_clk_in(cpu_clk_in),
  .mode_ntsc (mode_ntsc),
  .step_pal  (step_pal),
  .step_ntsc (step_ntsc),
  .pix_valid (pix_valid),
  .pix_idx   (pix_idx),
  .grp_start (grp_start),
  .pix_fire  (pix_fire)
);

// File: tb/pxs_seq_top_tb_top.sv
module pxs_seq_top_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cpu_clk_in = 1'b0;
  logic       mode_ntsc = 1'b0;
  logic [7:0] step_pal = 8'd5;
  logic [7:0] step_ntsc = 8'd4;
  logic       pix_valid;
  logic [2:0] pix_idx;

  int n_vec = 0;
  int n_bad = 0;
  int cyc   = 0;
  bit done  = 1'b0;

  typedef struct {
    int    at;
    int    idx;
    string tag;
  } exp_t;
  exp_t exp_q[$];

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  pxs_seq_top dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .cpu_clk_in(cpu_clk_in),
    .mode_ntsc (mode_ntsc),
    .step_pal  (step_pal),
    .step_ntsc (step_ntsc),
    .pix_valid (pix_valid),
    .pix_idx   (pix_idx)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // Driver: one CPU period, rising edge now; pushes the expected strobes.
  task automatic run_group(input bit mode, input logic [7:0] sp, input logic [7:0] sn,
                           input int high, input int low, input string tag,
                           input bit flip);
    int s;
    int n0;
    mode_ntsc  = mode;
    step_pal   = sp;
    step_ntsc  = sn;
    cpu_clk_in = 1'b1;
    n0 = cyc;
    s = mode ? int'(sn) : int'(sp);
    if (s == 0) s = 1;
    for (int j = 0; j < 8; j++)
      if (j * s < high + low) exp_q.push_back('{n0 + 3 + j * s, j, tag});
    repeat (high) @(negedge clk);
    cpu_clk_in = 1'b0;
    if (flip) begin
      mode_ntsc = ~mode;
      step_pal  = sp + 8'd9;
      step_ntsc = sn + 8'd9;
    end
    repeat (low) @(negedge clk);
  endtask

  // Monitor: compare each strobe against the head of the queue.
  always @(negedge clk) begin
    if (rst_n && pix_valid) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R5/R2 unexpected strobe idx", int'(pix_idx), -1);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        check(cyc == e.at, {e.tag, " strobe cycle"}, cyc, e.at);
        check(int'(pix_idx) == e.idx, {e.tag, " strobe index"}, int'(pix_idx), e.idx);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      n_vec++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(pix_valid == 1'b0, "R1 valid in reset", int'(pix_valid), 0);
    check(pix_idx == 3'd0, "R1 index in reset", int'(pix_idx), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(pix_valid == 1'b0, "R1 valid after reset", int'(pix_valid), 0);
    check(pix_idx == 3'd0, "R1 index after reset", int'(pix_idx), 0);

    // R2 R3 R4: full group, last pixel equal width (8*5 = 40).
    run_group(1'b0, 8'd5, 8'd4, 20, 20, "R4 pal step5", 1'b0);
    // R5: last pixel stretched (step 4, period 40).
    run_group(1'b1, 8'd5, 8'd4, 20, 20, "R5 ntsc step4 stretch", 1'b0);
    // R6: step 6 in 40 cycles -> only 7 pixels.
    run_group(1'b0, 8'd6, 8'd4, 20, 20, "R6 truncate step6", 1'b0);
    // R6 boundary: pixel 7 slot equals next start (step 5, period 35).
    run_group(1'b0, 8'd5, 8'd4, 17, 18, "R6 boundary", 1'b0);
    // R7: zero step behaves as one.
    run_group(1'b1, 8'd5, 8'd0, 6, 6, "R7 zero step", 1'b0);
    // R8: mode and steps change mid-group.
    run_group(1'b0, 8'd3, 8'd7, 6, 30, "R8 mid-group change", 1'b1);
    // R4 with the other mode after the change; R2 short high phase.
    run_group(1'b1, 8'd3, 8'd7, 2, 60, "R2 R4 ntsc step7", 1'b0);
    // R5: long tail with no further strobes.
    run_group(1'b0, 8'd4, 8'd9, 30, 100, "R5 long tail", 1'b0);

    check(exp_q.size() == 0, "R5 R6 pending strobes left", exp_q.size(), 0);
    check(pix_idx == 3'd7, "R5 index holds at last", int'(pix_idx), 7);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule